// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This unit services a cache miss by fetching one full line from a memory port that returns a single word per beat. It does not start at word 0. It first requests the word that caused the miss. It then requests the words above it up to the top of the line, and then the words from word 0 upward, until every word of the line has been requested once. Each returned word is written straight into the line storage through a per-word write port.

The missed word is handed to the CPU one cycle after it arrives, so execution can resume while the rest of the line is still in flight. During the fill, a per-word valid vector records which words have landed. A CPU read that falls inside the line being filled is granted once its word is present and is stalled while it is not. A single-cycle completion pulse marks the end of the fill. Only after that pulse can the unit accept another miss.

Top module: `cwf_fill_unit`

## Requirements
- R1: The first memory request after a miss is accepted carries the missed word's address. The word index is taken from address bits [4:2] with the default 8-word, 4-byte-word line.
- R2: The requests cover every word of the line exactly once, in wrapped order. Request k uses word index (missed index + k) mod 8, and all requests share the missed line's upper address bits.
- R3: `cpuDataValid` pulses exactly once per fill, one cycle after the first response beat. `cpuData` then carries that beat's data, and at that point only one word of the line has been written.
- R4: Every response beat during a fill drives `lineWrEn` in the same cycle, with `lineWrIdx` equal to the word index of the matching request and `lineWrData` equal to the beat's data. The remaining words keep being written after the CPU has been released.
- R5: `lineValid` clears when a miss is accepted and gains bit i one cycle after word i is written. A CPU read of the filling line asserts `cpuRdGrant` when its word bit is set and `cpuRdStall` otherwise. A read outside the line asserts neither output.
- R6: `missReady` is low from the cycle after a miss is accepted until the fill completes. A `missValid` strobe during that time has no effect on the requests being issued.
- R7: `fillDone` is a single-cycle pulse in the cycle after the last word is written, and `missReady` is high in that same cycle.
- R8: While `memReqValid` is high and `memReqReady` is low, the request stays valid on the next cycle with the same address.
- R9: After reset, `memReqValid`, `cpuDataValid`, `fillDone` and `lineValid` are all zero, and `missReady` is one.
- R10: A response beat that arrives while no fill is in progress writes nothing and changes no valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Strobe that starts a fill |
| missAddr | input | ADDR_W | Byte address of the missed word |
| missReady | output | 1 | High when a new miss can be accepted |
| memReqValid | output | 1 | A word request is offered |
| memReqReady | input | 1 | The memory accepts the offered request |
| memReqAddr | output | ADDR_W | Word-aligned address of the request |
| memRspValid | input | 1 | A response word is present this cycle |
| memRspData | input | DATA_W | Response word, returned in request order |
| lineWrEn | output | 1 | Write strobe into the line storage |
| lineWrIdx | output | IDX_W | Word index to write |
| lineWrData | output | DATA_W | Word to write |
| lineValid | output | LINE_WORDS | Per-word presence bits of the current line |
| cpuDataValid | output | 1 | Pulse that releases the CPU with the missed word |
| cpuData | output | DATA_W | The missed word |
| cpuRdValid | input | 1 | CPU read probe |
| cpuRdAddr | input | ADDR_W | Address of the CPU read probe |
| cpuRdGrant | output | 1 | The probed word is present in the filling line |
| cpuRdStall | output | 1 | The probed word belongs to the line but has not yet arrived |
| fillDone | output | 1 | Fill-complete pulse |

## Verification
The hardest situation to reach from the ports is a CPU probe of a word that is still missing, while requests are held back and responses arrive with gaps. Only then do the stall, grant and valid bits disagree from one cycle to the next.

The stimulus table varies the missed word, the request back-pressure pattern, the response spacing, and whether a competing miss strobe is raised during the fill. Throughout each fill, the bench probes a word that rotates every cycle around the line and compares the result with a presence mask it builds from the writes it has observed.

// File: rtl/cwf_fill_pkg.sv
package cwf_fill_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fillState_t;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic start;     // miss accepted this cycle
    logic reqFire;   // request handshake completes
    logic rspFire;   // response beat consumed
    logic firstRsp;  // beat carrying the missed word
    logic lastRsp;   // beat completing the line
  } fillStrb_t;

endpackage

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
  import cwf_fill_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int IDX_W = $clog2(LINE_WORDS),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  input  logic             memReqReady,
  input  logic             memRspValid,
  output logic             missReady,
  output logic             memReqValid,
  output logic             fillDone,
  output logic [CNT_W-1:0] reqCnt,
  output logic [CNT_W-1:0] rspCnt,
  output fillStrb_t        strb
);

  fillState_t state;

  always_comb begin
    missReady     = (state == ST_IDLE);
    memReqValid   = (state == ST_FILL) && (reqCnt < CNT_W'(LINE_WORDS));
    strb.start    = missValid && missReady;
    strb.reqFire  = memReqValid && memReqReady;
    strb.rspFire  = (state == ST_FILL) && memRspValid;
    strb.firstRsp = strb.rspFire && (rspCnt == '0);
    strb.lastRsp  = strb.rspFire && (rspCnt == CNT_W'(LINE_WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      reqCnt   <= '0;
      rspCnt   <= '0;
      fillDone <= 1'b0;
    end else begin
      fillDone <= strb.lastRsp;
      if (strb.start) begin
        state  <= ST_FILL;
        reqCnt <= '0;
        rspCnt <= '0;
      end else begin
        if (strb.reqFire) reqCnt <= reqCnt + 1'b1;
        if (strb.rspFire) rspCnt <= rspCnt + 1'b1;
        if (strb.lastRsp) state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/cwf_fill_dp.sv
module cwf_fill_dp
  import cwf_fill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int BYTE_OFF_W = 2,
  localparam int IDX_W = $clog2(LINE_WORDS),
  localparam int CNT_W = IDX_W + 1,
  localparam int TAG_W = ADDR_W - IDX_W - BYTE_OFF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fillStrb_t             strb,
  input  logic [CNT_W-1:0]      reqCnt,
  input  logic [CNT_W-1:0]      rspCnt,
  input  logic [ADDR_W-1:0]     missAddr,
  input  logic [DATA_W-1:0]     memRspData,
  input  logic                  cpuRdValid,
  input  logic [ADDR_W-1:0]     cpuRdAddr,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic                  lineWrEn,
  output logic [IDX_W-1:0]      lineWrIdx,
  output logic [DATA_W-1:0]     lineWrData,
  output logic [LINE_WORDS-1:0] lineValid,
  output logic                  cpuDataValid,
  output logic [DATA_W-1:0]     cpuData,
  output logic                  cpuRdGrant,
  output logic                  cpuRdStall
);

  logic [TAG_W-1:0] lineTag;
  logic [IDX_W-1:0] critIdx;
  logic             haveLine;
  logic [IDX_W-1:0] reqIdx;
  logic [IDX_W-1:0] rspIdx;
  logic [IDX_W-1:0] rdIdx;
  logic             rdMatch;

  // wrapped order falls out of modulo arithmetic on the index width
  always_comb begin
    reqIdx     = critIdx + reqCnt[IDX_W-1:0];
    rspIdx     = critIdx + rspCnt[IDX_W-1:0];
    memReqAddr = {lineTag, reqIdx, {BYTE_OFF_W{1'b0}}};
    lineWrEn   = strb.rspFire;
    lineWrIdx  = rspIdx;
    lineWrData = memRspData;
    rdIdx      = cpuRdAddr[BYTE_OFF_W +: IDX_W];
    rdMatch    = cpuRdValid && haveLine &&
                 (cpuRdAddr[ADDR_W-1 -: TAG_W] == lineTag);
    cpuRdGrant = rdMatch && lineValid[rdIdx];
    cpuRdStall = rdMatch && !lineValid[rdIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineTag      <= '0;
      critIdx      <= '0;
      haveLine     <= 1'b0;
      cpuDataValid <= 1'b0;
      cpuData      <= '0;
    end else begin
      cpuDataValid <= strb.firstRsp;
      if (strb.firstRsp) cpuData <= memRspData;
      if (strb.start) begin
        lineTag  <= missAddr[ADDR_W-1 -: TAG_W];
        critIdx  <= missAddr[BYTE_OFF_W +: IDX_W];
        haveLine <= 1'b1;
      end
    end
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rstN) lineValid[w] <= 1'b0;
      else if (strb.start) lineValid[w] <= 1'b0;
      else if (strb.rspFire && (rspIdx == IDX_W'(w))) lineValid[w] <= 1'b1;
    end
  end

endmodule

// File: rtl/cwf_fill_unit.sv
module cwf_fill_unit
  import cwf_fill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int BYTE_OFF_W = 2,
  localparam int IDX_W = $clog2(LINE_WORDS),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  missValid,
  input  logic [ADDR_W-1:0]     missAddr,
  output logic                  missReady,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [ADDR_W-1:0]     memReqAddr,
  input  logic                  memRspValid,
  input  logic [DATA_W-1:0]     memRspData,
  output logic                  lineWrEn,
  output logic [IDX_W-1:0]      lineWrIdx,
  output logic [DATA_W-1:0]     lineWrData,
  output logic [LINE_WORDS-1:0] lineValid,
  output logic                  cpuDataValid,
  output logic [DATA_W-1:0]     cpuData,
  input  logic                  cpuRdValid,
  input  logic [ADDR_W-1:0]     cpuRdAddr,
  output logic                  cpuRdGrant,
  output logic                  cpuRdStall,
  output logic                  fillDone
);

  fillStrb_t        strb;
  logic [CNT_W-1:0] reqCnt;
  logic [CNT_W-1:0] rspCnt;

  cwf_fill_ctrl #(.LINE_WORDS(LINE_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .missValid(missValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .missReady(missReady), .memReqValid(memReqValid), .fillDone(fillDone),
    .reqCnt(reqCnt), .rspCnt(rspCnt), .strb(strb)
  );

  cwf_fill_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LINE_WORDS(LINE_WORDS), .BYTE_OFF_W(BYTE_OFF_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqCnt(reqCnt), .rspCnt(rspCnt),
    .missAddr(missAddr), .memRspData(memRspData),
    .cpuRdValid(cpuRdValid), .cpuRdAddr(cpuRdAddr),
    .memReqAddr(memReqAddr), .lineWrEn(lineWrEn), .lineWrIdx(lineWrIdx),
    .lineWrData(lineWrData), .lineValid(lineValid),
    .cpuDataValid(cpuDataValid), .cpuData(cpuData),
    .cpuRdGrant(cpuRdGrant), .cpuRdStall(cpuRdStall)
  );

endmodule

// File: rtl/cwf_fill_checker.sv
module cwf_fill_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int BYTE_OFF_W = 2,
  localparam int IDX_W = $clog2(LINE_WORDS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     missAddr,
  input logic                  missReady,
  input logic                  memReqValid,
  input logic                  memReqReady,
  input logic [ADDR_W-1:0]     memReqAddr,
  input logic                  lineWrEn,
  input logic [LINE_WORDS-1:0] lineValid,
  input logic                  cpuDataValid,
  input logic                  cpuRdGrant,
  input logic                  cpuRdStall,
  input logic                  fillDone
);

  p_first_word_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |->
      memReqAddr[BYTE_OFF_W +: IDX_W] == $past(missAddr[BYTE_OFF_W +: IDX_W]));

  p_release_after_beat_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuDataValid |-> $past(lineWrEn));

  p_write_only_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    lineWrEn |-> !missReady);

  p_valid_monotonic_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!missReady && !$past(missReady)) |-> (($past(lineValid) & ~lineValid) == '0));

  p_rd_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuRdGrant && cpuRdStall));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |=> !fillDone);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |-> missReady);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

endmodule

bind cwf_fill_unit cwf_fill_checker #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .BYTE_OFF_W(BYTE_OFF_W)
) chk_i (
  .clk(clk), .rstN(rstN), .missAddr(missAddr), .missReady(missReady),
  .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .lineWrEn(lineWrEn), .lineValid(lineValid),
  .cpuDataValid(cpuDataValid), .cpuRdGrant(cpuRdGrant),
  .cpuRdStall(cpuRdStall), .fillDone(fillDone)
);

// File: tb/cwf_fill_unit_tb_top.sv
module cwf_fill_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {missAddr, request-ready mask, response gap, competing-miss flag}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h0000_1000, 8'hFF, 4'd1, 4'd0},
    {32'h0000_205C, 8'hAA, 4'd2, 4'd0},
    {32'h1234_568C, 8'h6D, 4'd3, 4'd1},
    {32'hABCD_0014, 8'hFF, 4'd1, 4'd0},
    {32'h0000_0FE4, 8'h0F, 4'd4, 4'd1},
    {32'h7777_7018, 8'hF7, 4'd1, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        missReady;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        lineWrEn;
  logic [2:0]  lineWrIdx;
  logic [31:0] lineWrData;
  logic [7:0]  lineValid;
  logic        cpuDataValid;
  logic [31:0] cpuData;
  logic        cpuRdValid = 1'b0;
  logic [31:0] cpuRdAddr = '0;
  logic        cpuRdGrant;
  logic        cpuRdStall;
  logic        fillDone;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cwf_fill_unit dut_i (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .missReady(missReady), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .lineWrEn(lineWrEn), .lineWrIdx(lineWrIdx), .lineWrData(lineWrData),
    .lineValid(lineValid), .cpuDataValid(cpuDataValid), .cpuData(cpuData),
    .cpuRdValid(cpuRdValid), .cpuRdAddr(cpuRdAddr), .cpuRdGrant(cpuRdGrant),
    .cpuRdStall(cpuRdStall), .fillDone(fillDone)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish();
    end
  end

  task automatic runVec(input logic [31:0] addr, input logic [7:0] rmask,
                        input int gap, input bit intr);
    logic [31:0] reqQ [16];
    logic [31:0] line = {addr[31:5], 5'b0};
    logic [2:0]  crit = addr[4:2];
    logic [7:0]  mask = '0;
    logic [7:0]  pend = '0;
    logic [31:0] prevAddr = '0;
    bit prevStall = 0;
    int head = 0, tail = 0, writes = 0, relCnt = 0;
    bit errOrder = 0, errWr = 0, errRd = 0, errBusy = 0, errHold = 0;
    bit errRel = 0, errDone = 0, doneOk = 0, rspGo;
    logic [2:0]  rdWord;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      mask |= pend;
      pend = '0;
      missValid = (cyc == 0) || (intr && cyc > 1 && writes < 8);
      missAddr = (cyc == 0) ? addr : ~addr;
      memReqReady = rmask[cyc % 8];
      rspGo = (head < tail) && (cyc % gap == 0);
      memRspValid = rspGo;
      memRspData = rspGo ? memWord(reqQ[head]) : 32'h0;
      rdWord = crit + 3'(cyc);
      cpuRdValid = 1'b1;
      cpuRdAddr = line | {27'b0, rdWord, 2'b00};
      #1;
      if (cyc >= 1 && writes < 8 && missReady) errBusy = 1;
      if (cyc >= 1 && (lineValid !== mask || cpuRdGrant !== mask[rdWord] ||
                       cpuRdStall !== !mask[rdWord])) errRd = 1;
      if (cpuDataValid) begin
        relCnt++;
        if (cpuData !== memWord(line | {27'b0, crit, 2'b00}) || writes != 1) errRel = 1;
      end
      if (prevStall && (memReqValid !== 1'b1 || memReqAddr !== prevAddr)) errHold = 1;
      prevStall = memReqValid && !memReqReady;
      prevAddr = memReqAddr;
      if (writes == 8) begin
        doneOk = (fillDone === 1'b1) && (missReady === 1'b1);
        break;
      end
      if (fillDone) errDone = 1;
      if (memReqValid && memReqReady) begin
        if (tail >= 8 || memReqAddr !== (line | {27'b0, 3'(crit + 3'(tail)), 2'b00}))
          errOrder = 1;
        if (tail < 16) reqQ[tail] = memReqAddr;
        tail++;
      end
      if (rspGo) begin
        if (lineWrEn !== 1'b1 || lineWrIdx !== reqQ[head][4:2] ||
            lineWrData !== memWord(reqQ[head])) errWr = 1;
        pend[reqQ[head][4:2]] = 1'b1;
        writes++;
        head++;
      end else if (lineWrEn) errWr = 1;
    end
    missValid = 1'b0;
    memRspValid = 1'b0;
    cpuRdValid = 1'b0;
    check(reqQ[0][4:2] == crit, "R1 first request word", 32'(reqQ[0][4:2]), 32'(crit));
    check(!errOrder && tail == 8, "R2 wrapped request order", tail, 8);
    check(relCnt == 1 && !errRel, "R3 early release", relCnt, 1);
    check(!errWr && writes == 8, "R4 line writes", writes, 8);
    check(!errRd && mask == 8'hFF, "R5 valid/stall/grant", 32'(mask), 32'hFF);
    check(!errBusy, "R6 busy ignores miss", 32'(errBusy), 0);
    check(doneOk && !errDone, "R7 fill done pulse", 32'(doneOk), 1);
    check(!errHold, "R8 request hold", 32'(errHold), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check(memReqValid === 1'b0, "R9 memReqValid", 32'(memReqValid), 0);
    check(missReady === 1'b1, "R9 missReady", 32'(missReady), 1);
    check(lineValid === 8'h00, "R9 lineValid", 32'(lineValid), 0);
    check(cpuDataValid === 1'b0 && fillDone === 1'b0, "R9 pulses",
          32'({cpuDataValid, fillDone}), 0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++)
      runVec(VEC[v][47:16], VEC[v][15:8], int'(VEC[v][7:4]), VEC[v][0]);

    // R10 response while idle
    @(negedge clk);
    memRspValid = 1'b1;
    memRspData = 32'hDEAD_BEEF;
    #1;
    check(lineWrEn === 1'b0, "R10 idle response no write", 32'(lineWrEn), 0);
    @(negedge clk);
    memRspValid = 1'b0;
    #1;
    check(lineValid === 8'hFF && cpuDataValid === 1'b0, "R10 idle response no state change",
          32'(lineValid), 32'hFF);

    // R5 probe outside the last line, then inside it
    cpuRdValid = 1'b1;
    cpuRdAddr = 32'h5555_0000;
    #1;
    check(!cpuRdGrant && !cpuRdStall, "R5 other line neither",
          32'({cpuRdGrant, cpuRdStall}), 0);
    cpuRdAddr = 32'h7777_7004;
    #1;
    check(cpuRdGrant && !cpuRdStall, "R5 completed line grant",
          32'({cpuRdGrant, cpuRdStall}), 32'b10);
    cpuRdValid = 1'b0;
    finish();
  end

endmodule